// File: doc/BRIEF.md
# Auto-Wakeup Halt Sequencer

This block lets a processor leave its halt state by itself once a programmed interval has passed. When the CPU issues a halt command, the main oscillator request drops and the CPU is held. If auto-wakeup is enabled, a counter driven by a slow always-on clock then measures the interval. The slow clock is first divided by a fixed factor of 16. A programmable 8-bit prescaler then sets how many of those divided ticks make up the interval.

When the interval ends, the block does four things. It sets a wakeup flag, raises an interrupt and turns the main oscillator request back on straight away. It then keeps the CPU held for 64 main-clock cycles while the oscillator settles. Software clears the flag and the interrupt by reading the control/status register. An external halt-exit interrupt also ends the halt, whether it was already pending when the halt began or arrives during it.

A measurement mode can be switched on while the CPU is running. It passes the slow clock out to a capture input, so software can calibrate the slow clock against the main clock.

Top module: `awu_halt_seq`

## Requirements
- R1: After reset, osc_en is 1, cpu_hold, irq, int_unmask and meas_out are 0, and both registers read 0.
- R2: A halt_cmd pulse while running makes osc_en 0 and cpu_hold 1 from the next cycle on. int_unmask is 1 for exactly that first halted cycle.
- R3: With the enable bit set, the block wakes on its own after 16*max(P,1) slow-clock cycles. P is the prescaler value latched at halt entry. Up to 4 further slow cycles plus 4 main cycles of synchronization delay are allowed.
- R4: With the enable bit clear, a halt never ends on its own. osc_en stays 0.
- R5: On an automatic wakeup, irq goes to 1 and the flag bit (control/status bit 2) reads 1.
- R6: After osc_en returns to 1, cpu_hold stays 1 for exactly 64 main-clock cycles and then drops.
- R7: A read of the control/status register (reg_addr 0, reg_re 1) clears the flag and irq at the clock edge of the read.
- R8: If a control/status read and a flag set fall on the same edge, the flag ends up set.
- R9: A prescaler write made during a halt does not change that halt's interval. It applies from the next halt entry.
- R10: ext_wake at 1 during a halt ends it (osc_en 1, then the 64-cycle hold) without setting the flag. ext_wake already high at entry ends the halt at once.
- R11: With the measure bit set (control/status bit 1), meas_out follows slow_clk while running. It stays 0 whenever cpu_hold is 1.
- R12: Register map: address 0 holds bit 0 enable, bit 1 measure and bit 2 flag (read-only), with the other bits 0. Address 1 is the 8-bit prescaler and reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk | input | 1 | Always-on slow clock |
| halt_cmd | input | 1 | CPU halt command pulse |
| ext_wake | input | 1 | Halt-exit-capable interrupt pending |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 1 | Register select: 0 control/status, 1 prescaler |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| osc_en | output | 1 | Main oscillator request |
| cpu_hold | output | 1 | Holds CPU execution |
| int_unmask | output | 1 | One-cycle pulse that clears the global interrupt mask at halt entry |
| irq | output | 1 | Wakeup interrupt |
| meas_out | output | 1 | Slow clock routed to the capture input |

## Verification
The bench sweeps the prescaler over 0, small values and 255, and checks each interval against 16*max(P,1) slow periods. A design that mishandles a zero prescaler would wait 256 ticks instead of 1. A design that is off by one tick would land outside the window.

The bench keeps reading the status register right up to the wake edge. A design that lets the read win that collision would lose the wakeup flag. The bench also counts the stabilization hold cycle by cycle, so an off-by-one hold is caught.

Finally, the bench rewrites the prescaler during a halt. A design that reloads the prescaler live would wake early and fail the check.

// File: rtl/awu_halt_seq.sv
module awu_halt_seq #(
  parameter int DIV_W       = 4,
  parameter int PSC_W       = 8,
  parameter int STAB_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_clk,
  input  logic             halt_cmd,
  input  logic             ext_wake,
  input  logic             reg_we,
  input  logic             reg_re,
  input  logic             reg_addr,
  input  logic [PSC_W-1:0] reg_wdata,
  output logic [PSC_W-1:0] reg_rdata,
  output logic             osc_en,
  output logic             cpu_hold,
  output logic             int_unmask,
  output logic             irq,
  output logic             meas_out
);
  localparam int STAB_W = $clog2(STAB_CYCLES);

  typedef enum logic [1:0] {S_RUN, S_HALT, S_STAB} st_t;

  st_t              state;
  logic [STAB_W-1:0] stab_cnt;
  logic             en, meas, flag, arm_q;
  logic [PSC_W-1:0] psc, psc_cap;
  logic [2:0]       wk_m;
  logic             wake_edge, csr_rd;

  logic [1:0]       run_s;
  logic [DIV_W-1:0] div;
  logic [PSC_W-1:0] cnt;
  logic             wake_s;

  assign wake_edge = wk_m[1] & ~wk_m[2];
  assign csr_rd    = reg_re & ~reg_addr;
  assign osc_en    = state != S_HALT;
  assign cpu_hold  = state != S_RUN;
  assign irq       = flag;
  assign meas_out  = slow_clk & meas & (state == S_RUN);
  assign reg_rdata = reg_addr ? psc : PSC_W'({flag, meas, en});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_RUN;
      stab_cnt   <= '0;
      en         <= 1'b0;
      meas       <= 1'b0;
      flag       <= 1'b0;
      arm_q      <= 1'b0;
      psc        <= '0;
      psc_cap    <= PSC_W'(1);
      wk_m       <= '0;
      int_unmask <= 1'b0;
    end else begin
      int_unmask <= 1'b0;
      wk_m       <= {wk_m[1:0], wake_s};
      arm_q      <= (state == S_HALT) && en;
      if (reg_we) begin
        if (reg_addr) psc <= reg_wdata;
        else begin
          en   <= reg_wdata[0];
          meas <= reg_wdata[1];
        end
      end
      if (wake_edge)   flag <= 1'b1;
      else if (csr_rd) flag <= 1'b0;
      case (state)
        S_RUN: if (halt_cmd) begin
          state      <= S_HALT;
          int_unmask <= 1'b1;
          psc_cap    <= (psc == '0) ? PSC_W'(1) : psc;
        end
        S_HALT: if (wake_edge || ext_wake) begin
          state    <= S_STAB;
          stab_cnt <= '0;
        end
        default: begin
          if (stab_cnt == STAB_W'(STAB_CYCLES - 1)) state <= S_RUN;
          else stab_cnt <= stab_cnt + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge slow_clk or negedge rst_n) begin
    if (!rst_n) begin
      run_s  <= '0;
      div    <= '0;
      cnt    <= '0;
      wake_s <= 1'b0;
    end else begin
      run_s <= {run_s[0], arm_q};
      if (!run_s[1]) begin
        div    <= '0;
        cnt    <= psc_cap;
        wake_s <= 1'b0;
      end else if (!wake_s) begin
        div <= div + 1'b1;
        if (div == '1) begin
          if (cnt <= PSC_W'(1)) wake_s <= 1'b1;
          else cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/awu_halt_seq_chk.sv
module awu_halt_seq_chk #(
  parameter int STAB_CYCLES = 64
) (
  input logic clk,
  input logic rst_n,
  input logic halt_cmd,
  input logic reg_re,
  input logic reg_addr,
  input logic osc_en,
  input logic cpu_hold,
  input logic int_unmask,
  input logic irq,
  input logic meas_out
);
  logic [15:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_cnt <= '0;
    else if (cpu_hold && osc_en) hold_cnt <= hold_cnt + 1'b1;
    else hold_cnt <= '0;
  end

  // R2
  halt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> cpu_hold);
  // R2
  halt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_en) |-> (int_unmask && $past(halt_cmd)));
  // R6
  stab_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_hold) |-> (hold_cnt == 16'(STAB_CYCLES)));
  // R7
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(reg_re && !reg_addr));
  // R5
  wake_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> osc_en);
  // R11
  meas_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meas_out |-> !cpu_hold);
endmodule

bind awu_halt_seq awu_halt_seq_chk #(.STAB_CYCLES(STAB_CYCLES)) u_chk (.*);

// File: tb/awu_halt_seq_bench.sv
`timescale 1ns/1ps
module awu_halt_seq_bench;
  localparam int TM = 20;
  localparam int TS = 160;

  logic clk = 0, slow_clk = 0, rst_n = 0;
  logic halt_cmd = 0, ext_wake = 0, reg_we = 0, reg_re = 0, reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic osc_en, cpu_hold, int_unmask, irq, meas_out;
  int checks = 0, errors = 0;

  always #(TM/2) clk = ~clk;
  always #(TS/2) slow_clk = ~slow_clk;

  awu_halt_seq u_awu_halt_seq (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); reg_re = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_re = 0;
  endtask

  task automatic enter_halt(output time t0);
    @(negedge clk); halt_cmd = 1;
    @(negedge clk); halt_cmd = 0; t0 = $time - TM/2;
    chk(osc_en == 0 && cpu_hold == 1, "R2 halted", int'(osc_en), 0);
    chk(int_unmask == 1, "R2 unmask pulse", int'(int_unmask), 1);
    @(negedge clk);
    chk(int_unmask == 0, "R2 unmask one cycle", int'(int_unmask), 0);
  endtask

  task automatic count_hold(input string tag);
    int n = 0;
    while (cpu_hold) begin n++; @(negedge clk); end
    chk(n == 64, tag, n, 64);
  endtask

  task automatic auto_wake(input int eff, input bit mid_wr, input logic [7:0] newp);
    time t0, t1, lo, hi;
    logic [7:0] d;
    enter_halt(t0);
    if (mid_wr) begin
      reg_we = 1; reg_addr = 1; reg_wdata = newp;
      @(negedge clk); reg_we = 0;
    end
    reg_re = 1; reg_addr = 0;
    while (!osc_en) @(negedge clk);
    reg_re = 0; t1 = $time;
    lo = time'(16 * eff * TS);
    hi = time'((16 * eff + 4) * TS + 4 * TM + TM);
    chk(t1 - t0 >= lo && t1 - t0 <= hi, "R3 R9 wake delay", int'(t1 - t0), int'(lo));
    count_hold("R6 hold length");
    chk(irq == 1, "R5 irq set", int'(irq), 1);
    rd(0, d);
    chk(d[2] == 1, "R8 R5 flag survives collision read", int'(d[2]), 1);
    chk(irq == 0, "R7 irq cleared by read", int'(irq), 0);
    rd(0, d);
    chk(d[2] == 0, "R7 flag cleared", int'(d[2]), 0);
  endtask

  initial begin
    #(200000 * TM);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int seen0, seen1;
    time t0;
    int plist[6] = '{0, 1, 2, 5, 16, 255};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(osc_en == 1 && cpu_hold == 0 && irq == 0 && int_unmask == 0 && meas_out == 0,
        "R1 reset outputs", int'({osc_en, cpu_hold, irq, int_unmask, meas_out}), 16);
    rd(0, d); chk(d == 0, "R1 csr reset", d, 0);
    rd(1, d); chk(d == 0, "R1 psc reset", d, 0);

    wr(0, 8'h01); rd(0, d); chk(d == 8'h01, "R12 csr readback", d, 1);
    wr(1, 8'hA5); rd(1, d); chk(d == 8'hA5, "R12 psc readback", d, 8'hA5);

    foreach (plist[i]) begin
      wr(1, 8'(plist[i]));
      auto_wake(plist[i] == 0 ? 1 : plist[i], 0, 0);
    end

    // R9: write during halt does not apply to the current interval
    wr(1, 8'd3);
    auto_wake(3, 1, 8'd1);
    auto_wake(1, 0, 0);

    // R4 and R10: no auto wake when disabled, external wake exits
    wr(0, 8'h00); wr(1, 8'd2);
    enter_halt(t0);
    repeat (1000) @(negedge clk);
    chk(osc_en == 0, "R4 stays halted", int'(osc_en), 0);
    ext_wake = 1; @(negedge clk); ext_wake = 0;
    chk(osc_en == 1, "R10 ext wake", int'(osc_en), 1);
    count_hold("R10 R6 hold after ext wake");
    rd(0, d); chk(d[2] == 0, "R10 no flag on ext wake", int'(d[2]), 0);

    // R10: pending interrupt at entry
    wr(0, 8'h01);
    ext_wake = 1;
    @(negedge clk); halt_cmd = 1; @(negedge clk); halt_cmd = 0;
    @(negedge clk); ext_wake = 0;
    chk(osc_en == 1, "R10 immediate exit", int'(osc_en), 1);
    while (cpu_hold) @(negedge clk);
    rd(0, d); chk(d[2] == 0, "R10 no flag immediate", int'(d[2]), 0);

    // R11 measurement mode
    wr(0, 8'h02);
    rd(0, d); chk(d == 8'h02, "R12 measure bit readback", d, 2);
    seen0 = 0; seen1 = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); #1;
      if (meas_out) seen1++; else seen0++;
      chk(meas_out == slow_clk, "R11 follows slow clock", int'(meas_out), int'(slow_clk));
    end
    chk(seen0 > 0 && seen1 > 0, "R11 toggles in run", seen1, 20);
    enter_halt(t0);
    seen1 = 0;
    for (int k = 0; k < 40; k++) begin @(negedge clk); #1; if (meas_out) seen1++; end
    chk(seen1 == 0, "R11 silent in halt", seen1, 0);
    ext_wake = 1; @(negedge clk); ext_wake = 0;
    seen1 = 0;
    while (cpu_hold) begin #1; if (meas_out) seen1++; @(negedge clk); end
    chk(seen1 == 0, "R11 silent in hold", seen1, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule